// File: doc/BRIEF.md
# Open-Row DRAM Command Sequencer

This block turns host read and write requests into memory commands for one pseudo channel of sixteen independent banks. Each request carries a 32-bit byte address, a direction flag and an identifier. The address is split with a fixed bank-interleaved layout: the lowest three bits select a byte inside a word and are dropped, the column comes next, then the bank, and the row sits at the top. Consecutive addresses therefore fill one open row before the mapping moves on to another bank.

The sequencer keeps an open-page record for every bank: whether a row is open, and which row. A request to an open bank with a matching row goes straight to the column command. A request to a bank holding another row first closes it with a precharge and then opens the new row with an activate. A bank that is already closed gets the activate only. Minimum spacings between commands are parameters counted in clock cycles. After each column command a start-of-data pulse appears a fixed read or write latency later, carrying the request's identifier. Each burst moves 32 bytes as four beats on a 64-bit bus using both clock edges, so it holds the data bus for two clocks. Requests are handled one at a time and in arrival order.

Top module: `dram_cmd_seq`

## Requirements
- R1: While a command is issued, cmd_row carries address bits [31:17], cmd_bank carries bits [16:13] and cmd_col carries bits [12:3] of the request being served.
- R2: Address bits [2:0] have no effect on any command or on its fields.
- R3: Commands are coded on cmd as 000 idle, 001 precharge, 010 activate, 011 read, 100 write. After reset every bank is closed, so the first access to a bank issues an activate without a precharge before it.
- R4: A request to a bank that holds a different open row issues precharge, then activate, then the read or write, in that order.
- R5: A request whose row is already open in its bank issues the read or write with no precharge and no activate.
- R6: On one bank, an activate comes at least T_RP cycles after its precharge, a read or write at least T_RCD cycles after its activate, and a precharge at least T_RAS cycles after its activate. Each command goes out in the first cycle its spacings allow, unless R7 holds it back.
- R7: Two column commands are at least T_CCD cycles apart. A column command is held back while its data window would start fewer than BURST_CYC cycles from an already scheduled one.
- R8: req_ready is high only when no request is in progress. It falls on the cycle after a request is accepted and rises again on the cycle after that request's column command. Commands appear only while req_ready is low.
- R9: A column command in cycle c raises data_start for one cycle in cycle c+RD_LAT for a read or c+WR_LAT for a write, with data_start_id equal to the request's identifier and data_start_write equal to 1 for a write.
- R10: Banks are tracked independently. Commands to one bank leave the open row of every other bank unchanged. A precharge or activate is not held back by a data window that is still pending from an earlier burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Sequencer is idle and takes the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 32 | Byte address of the request |
| req_id | input | ID_W | Request identifier |
| cmd | output | 3 | Command code this cycle |
| cmd_bank | output | 4 | Target bank of the command |
| cmd_row | output | 15 | Row field of the command |
| cmd_col | output | 10 | Column field of the command |
| data_start | output | 1 | First cycle of a burst's data window |
| data_start_id | output | ID_W | Identifier of that burst |
| data_start_write | output | 1 | That burst is a write |

## Verification
The bench builds the block with its default values: T_RP and T_RCD of 7, T_RAS of 17, T_CCD of 2, read latency 14, write latency 4 and a two-cycle burst. With these values, a row miss right after an activate has to wait on T_RAS, not on T_RCD. A write to a closed bank that follows a read lands its short-latency data window on top of the read's, which forces the column hold-off of R7. The request sequence covers closed, hit and miss cases on three banks, including the all-ones address. While the sequencer is busy, the bench keeps presenting stray requests to show that none is taken in.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 3;
    localparam int COL_W  = 10;
    localparam int BANK_W = 4;
    localparam int ROW_W  = 15;
    localparam int NBANK  = 1 << BANK_W;

    typedef enum logic [2:0] {
        CMD_NOP = 3'b000,
        CMD_PRE = 3'b001,
        CMD_ACT = 3'b010,
        CMD_RD  = 3'b011,
        CMD_WR  = 3'b100
    } cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } dram_loc_t;

    function automatic dram_loc_t split_addr(input logic [ADDR_W-1:0] a);
        dram_loc_t l;
        l.col  = a[OFS_W +: COL_W];
        l.bank = a[OFS_W + COL_W +: BANK_W];
        l.row  = a[OFS_W + COL_W + BANK_W +: ROW_W];
        return l;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcs_addr_split.sv
module dcs_addr_split
    import dcs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output dram_loc_t         loc_o
);

    logic unused_byte_ofs;

    assign loc_o           = split_addr(addr_i);
    assign unused_byte_ofs = ^addr_i[OFS_W-1:0];

endmodule

// File: rtl/dcs_bank_table.sv
module dcs_bank_table
    import dcs_pkg::*;
#(
    parameter int T_RP  = 7,
    parameter int T_RCD = 7,
    parameter int T_RAS = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] sel_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic              pre_i,
    input  logic              act_i,
    output logic              open_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              pre_ok_o,
    output logic              act_ok_o,
    output logic              col_ok_o
);

    localparam int TMAX  = max_of(max_of(T_RP, T_RCD), T_RAS);
    localparam int CNT_W = $clog2(TMAX + 1) + 1;
    localparam logic [CNT_W-1:0] SAT    = '1;
    localparam logic [CNT_W-1:0] RP_C   = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] RCD_C  = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] RAS_C  = CNT_W'(T_RAS);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    logic [NBANK-1:0] open_v;
    logic [NBANK-1:0] preok_v;
    logic [NBANK-1:0] actok_v;
    logic [NBANK-1:0] colok_v;
    logic [ROW_W-1:0] row_v [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam logic [BANK_W-1:0] MY_ID = BANK_W'(g);

        logic             mine;
        logic             open_r;
        logic [ROW_W-1:0] row_r;
        logic [CNT_W-1:0] since_act;
        logic [CNT_W-1:0] since_pre;

        assign mine = (sel_i == MY_ID);

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r    <= 1'b0;
                row_r     <= '0;
                since_act <= SAT;
                since_pre <= SAT;
            end else begin
                if (mine && act_i) begin
                    open_r    <= 1'b1;
                    row_r     <= row_i;
                    since_act <= ONE_C;
                end else if (since_act != SAT) begin
                    since_act <= since_act + ONE_C;
                end
                if (mine && pre_i) begin
                    open_r    <= 1'b0;
                    since_pre <= ONE_C;
                end else if (since_pre != SAT) begin
                    since_pre <= since_pre + ONE_C;
                end
            end
        end

        assign open_v[g]  = open_r;
        assign row_v[g]   = row_r;
        assign preok_v[g] = (since_act >= RAS_C);
        assign actok_v[g] = (since_pre >= RP_C);
        assign colok_v[g] = (since_act >= RCD_C);
    end

    assign open_o   = open_v[sel_i];
    assign row_o    = row_v[sel_i];
    assign pre_ok_o = preok_v[sel_i];
    assign act_ok_o = actok_v[sel_i];
    assign col_ok_o = colok_v[sel_i];

endmodule

// File: rtl/dcs_burst_slots.sv
module dcs_burst_slots #(
    parameter int ID_W      = 4,
    parameter int RD_LAT    = 14,
    parameter int WR_LAT    = 4,
    parameter int BURST_CYC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_i,
    input  logic            push_wr_i,
    input  logic [ID_W-1:0] push_id_i,
    output logic            free_rd_o,
    output logic            free_wr_o,
    output logic            start_o,
    output logic [ID_W-1:0] start_id_o,
    output logic            start_wr_o
);

    localparam int DEPTH  = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
    localparam int RD_IDX = RD_LAT - 1;
    localparam int WR_IDX = WR_LAT - 1;

    // entry j valid in cycle k: a data window opens in cycle k+j
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] wr_q;
    logic [ID_W-1:0]  id_q [DEPTH];

    always_comb begin
        free_rd_o = 1'b1;
        free_wr_o = 1'b1;
        for (int j = 0; j < DEPTH; j++) begin
            if (vld_q[j] && (j - RD_LAT < BURST_CYC) && (RD_LAT - j < BURST_CYC))
                free_rd_o = 1'b0;
            if (vld_q[j] && (j - WR_LAT < BURST_CYC) && (WR_LAT - j < BURST_CYC))
                free_wr_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            wr_q  <= '0;
        end else begin
            for (int j = 0; j < DEPTH - 1; j++) begin
                vld_q[j] <= vld_q[j+1];
                wr_q[j]  <= wr_q[j+1];
                id_q[j]  <= id_q[j+1];
            end
            vld_q[DEPTH-1] <= 1'b0;
            if (push_i) begin
                if (push_wr_i) begin
                    vld_q[WR_IDX] <= 1'b1;
                    wr_q[WR_IDX]  <= 1'b1;
                    id_q[WR_IDX]  <= push_id_i;
                end else begin
                    vld_q[RD_IDX] <= 1'b1;
                    wr_q[RD_IDX]  <= 1'b0;
                    id_q[RD_IDX]  <= push_id_i;
                end
            end
        end
    end

    assign start_o    = vld_q[0];
    assign start_id_o = id_q[0];
    assign start_wr_o = wr_q[0];

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
    import dcs_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int T_RP      = 7,
    parameter int T_RCD     = 7,
    parameter int T_RAS     = 17,
    parameter int T_CCD     = 2,
    parameter int RD_LAT    = 14,
    parameter int WR_LAT    = 4,
    parameter int BURST_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              data_start,
    output logic [ID_W-1:0]   data_start_id,
    output logic              data_start_write
);

    localparam int CCD_W = $clog2(T_CCD + 1) + 1;
    localparam logic [CCD_W-1:0] CCD_SAT = '1;
    localparam logic [CCD_W-1:0] CCD_C   = CCD_W'(T_CCD);
    localparam logic [CCD_W-1:0] CCD_ONE = CCD_W'(1);

    seq_state_e      st_q;
    dram_loc_t       cur_q;
    logic            cur_wr_q;
    logic [ID_W-1:0] cur_id_q;
    dram_loc_t       in_loc;

    logic             bk_open;
    logic [ROW_W-1:0] bk_row;
    logic             bk_pre_ok;
    logic             bk_act_ok;
    logic             bk_col_ok;
    logic             free_rd;
    logic             free_wr;
    logic             slot_ok;
    logic [CCD_W-1:0] since_col;
    logic             ccd_ok;
    cmd_e             issue;
    logic             col_issue;

    dcs_addr_split u_split (
        .addr_i (req_addr),
        .loc_o  (in_loc)
    );

    dcs_bank_table #(
        .T_RP  (T_RP),
        .T_RCD (T_RCD),
        .T_RAS (T_RAS)
    ) u_banks (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (cur_q.bank),
        .row_i    (cur_q.row),
        .pre_i    (issue == CMD_PRE),
        .act_i    (issue == CMD_ACT),
        .open_o   (bk_open),
        .row_o    (bk_row),
        .pre_ok_o (bk_pre_ok),
        .act_ok_o (bk_act_ok),
        .col_ok_o (bk_col_ok)
    );

    dcs_burst_slots #(
        .ID_W      (ID_W),
        .RD_LAT    (RD_LAT),
        .WR_LAT    (WR_LAT),
        .BURST_CYC (BURST_CYC)
    ) u_slots (
        .clk        (clk),
        .rst        (rst),
        .push_i     (col_issue),
        .push_wr_i  (cur_wr_q),
        .push_id_i  (cur_id_q),
        .free_rd_o  (free_rd),
        .free_wr_o  (free_wr),
        .start_o    (data_start),
        .start_id_o (data_start_id),
        .start_wr_o (data_start_write)
    );

    assign slot_ok = cur_wr_q ? free_wr : free_rd;
    assign ccd_ok  = (since_col >= CCD_C);

    // next command for the request in progress, decided from registered state only
    always_comb begin
        issue = CMD_NOP;
        if (st_q == ST_RUN) begin
            if (bk_open && (bk_row == cur_q.row)) begin
                if (bk_col_ok && ccd_ok && slot_ok)
                    issue = cur_wr_q ? CMD_WR : CMD_RD;
            end else if (bk_open) begin
                if (bk_pre_ok)
                    issue = CMD_PRE;
            end else if (bk_act_ok) begin
                issue = CMD_ACT;
            end
        end
    end

    assign col_issue = (issue == CMD_RD) || (issue == CMD_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_col <= CCD_SAT;
        end else if (col_issue) begin
            since_col <= CCD_ONE;
        end else if (since_col != CCD_SAT) begin
            since_col <= since_col + CCD_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cur_q    <= '0;
            cur_wr_q <= 1'b0;
            cur_id_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        st_q     <= ST_RUN;
                        cur_q    <= in_loc;
                        cur_wr_q <= req_write;
                        cur_id_q <= req_id;
                    end
                end
                default: begin
                    if (col_issue)
                        st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign cmd       = issue;
    assign cmd_bank  = cur_q.bank;
    assign cmd_row   = cur_q.row;
    assign cmd_col   = cur_q.col;

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
    import dcs_pkg::*;
#(
    parameter int T_RP      = 7,
    parameter int T_RCD     = 7,
    parameter int T_RAS     = 17,
    parameter int T_CCD     = 2,
    parameter int BURST_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [2:0]        cmd,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              data_start
);

    localparam int CAP = 1000;

    int since_act [NBANK];
    int since_pre [NBANK];
    int col_gap;
    int ds_gap;
    logic is_col;

    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++) begin
                since_act[b] <= CAP;
                since_pre[b] <= CAP;
            end
            col_gap <= CAP;
            ds_gap  <= CAP;
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                if (cmd == CMD_ACT && int'(cmd_bank) == b) since_act[b] <= 1;
                else if (since_act[b] < CAP) since_act[b] <= since_act[b] + 1;
                if (cmd == CMD_PRE && int'(cmd_bank) == b) since_pre[b] <= 1;
                else if (since_pre[b] < CAP) since_pre[b] <= since_pre[b] + 1;
            end
            if (is_col) col_gap <= 1;
            else if (col_gap < CAP) col_gap <= col_gap + 1;
            if (data_start) ds_gap <= 1;
            else if (ds_gap < CAP) ds_gap <= ds_gap + 1;
        end
    end

    a_r3_cmd_code: assert property (@(posedge clk) disable iff (rst)
        cmd <= 3'd4);

    a_r6_act_after_pre: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |-> since_pre[cmd_bank] >= T_RP);

    a_r6_col_after_act: assert property (@(posedge clk) disable iff (rst)
        is_col |-> since_act[cmd_bank] >= T_RCD);

    a_r6_pre_after_act: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> since_act[cmd_bank] >= T_RAS);

    a_r7_col_gap: assert property (@(posedge clk) disable iff (rst)
        is_col |-> col_gap >= T_CCD);

    a_r7_window_gap: assert property (@(posedge clk) disable iff (rst)
        data_start |-> ds_gap >= BURST_CYC);

    a_r8_busy_on_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> !req_ready);

    a_r8_ready_after_col: assert property (@(posedge clk) disable iff (rst)
        is_col |=> req_ready);

endmodule

bind dram_cmd_seq dcs_checker #(
    .T_RP      (T_RP),
    .T_RCD     (T_RCD),
    .T_RAS     (T_RAS),
    .T_CCD     (T_CCD),
    .BURST_CYC (BURST_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .cmd        (cmd),
    .cmd_bank   (cmd_bank),
    .data_start (data_start)
);

// File: tb/dram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_seq_tb_top;

    localparam int TRP = 7, TRCD = 7, TRAS = 17, TCCD = 2;
    localparam int RDL = 14, WRL = 4, BUR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_id = '0;
    logic [2:0]  cmd;
    logic [3:0]  cmd_bank;
    logic [14:0] cmd_row;
    logic [9:0]  cmd_col;
    logic        data_start;
    logic [3:0]  data_start_id;
    logic        data_start_write;

    always #2.5 clk = ~clk;

    dram_cmd_seq #(
        .ID_W(4), .T_RP(TRP), .T_RCD(TRCD), .T_RAS(TRAS), .T_CCD(TCCD),
        .RD_LAT(RDL), .WR_LAT(WRL), .BURST_CYC(BUR)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_id(req_id),
        .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .data_start(data_start), .data_start_id(data_start_id),
        .data_start_write(data_start_write)
    );

    typedef struct {
        bit          wr;
        logic [31:0] addr;
        logic [3:0]  id;
        int          gap;
    } req_t;

    typedef struct {
        int cyc;
        int id;
        bit wr;
    } pulse_t;

    req_t   rq[$];
    pulse_t pq[$];
    req_t   cur;
    bit     busy;
    int     open_row [16];
    int     last_act [16];
    int     last_pre [16];
    int     last_col;
    int     idle_cnt;
    int     checks = 0;
    int     errors = 0;
    int     seen_pulses = 0;
    int     total_reqs = 0;

    function automatic logic [31:0] mk(input int row, input int bank, input int col, input int low);
        return {15'(row), 4'(bank), 10'(col), 3'(low)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic add(input bit wr, input int row, input int bank, input int col,
                       input int low, input int id, input int gap);
        req_t r;
        r.wr = wr; r.addr = mk(row, bank, col, low); r.id = 4'(id); r.gap = gap;
        rq.push_back(r);
        total_reqs++;
    endtask

    int  b, r, lat, ecmd, eid;
    bit  ok, eds, ewr, accept, done;
    int  tail;

    initial begin
        // closed bank, hit with stray low bits, miss, write into read window, ...
        add(0, 5,      0,  3,     0, 1,  0);
        add(0, 5,      0,  7,     5, 2,  0);
        add(0, 9,      0,  1,     0, 3,  0);
        add(1, 1,      3,  2,     0, 4,  0);
        add(0, 9,      0,  4,     0, 5,  3);
        add(1, 1,      3,  9,     0, 6,  0);
        add(0, 32'h7fff, 15, 10'h3ff, 7, 7, 0);
        add(1, 2,      0,  0,     0, 8,  1);
        add(0, 1,      3,  5,     0, 9,  0);
        add(1, 0,      15, 0,     0, 10, 0);

        busy = 0; last_col = -1000; idle_cnt = 0; done = 0; tail = 0;
        for (int i = 0; i < 16; i++) begin
            open_row[i] = -1; last_act[i] = -1000; last_pre[i] = -1000;
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 R3: reset state
        chk(req_ready === 1'b1, "R8 reset ready", int'(req_ready), 1);
        chk(cmd === 3'd0, "R3 reset cmd", int'(cmd), 0);
        chk(data_start === 1'b0, "R9 reset data_start", int'(data_start), 0);
        rst = 1'b0;

        for (int k = 0; k < 3000 && !done; k++) begin
            @(negedge clk);
            // expected command in cycle k
            ecmd = 0;
            b = int'(cur.addr[16:13]);
            r = int'(cur.addr[31:17]);
            lat = cur.wr ? WRL : RDL;
            if (busy) begin
                if (open_row[b] == r) begin
                    ok = (k - last_act[b] >= TRCD) && (k - last_col >= TCCD);
                    foreach (pq[i]) begin
                        if ((pq[i].cyc - (k + lat) < BUR) && ((k + lat) - pq[i].cyc < BUR))
                            ok = 0;
                    end
                    if (ok) ecmd = cur.wr ? 4 : 3;
                end else if (open_row[b] >= 0) begin
                    if (k - last_act[b] >= TRAS) ecmd = 1;
                end else if (k - last_pre[b] >= TRP) begin
                    ecmd = 2;
                end
            end
            eds = 0; eid = 0; ewr = 0;
            foreach (pq[i]) if (pq[i].cyc == k) begin eds = 1; eid = pq[i].id; ewr = pq[i].wr; end

            chk(cmd === 3'(ecmd), "R3 R4 R5 R6 R10 cmd", int'(cmd), ecmd);
            if (ecmd != 0) begin
                chk(cmd_bank === cur.addr[16:13], "R1 bank", int'(cmd_bank), int'(cur.addr[16:13]));
                chk(cmd_row === cur.addr[31:17], "R1 row", int'(cmd_row), int'(cur.addr[31:17]));
                chk(cmd_col === cur.addr[12:3], "R1 R2 col", int'(cmd_col), int'(cur.addr[12:3]));
            end
            chk(req_ready === !busy, "R8 ready", int'(req_ready), int'(!busy));
            chk(data_start === eds, "R7 R9 data_start", int'(data_start), int'(eds));
            if (eds) begin
                seen_pulses++;
                chk(data_start_id === 4'(eid), "R9 id", int'(data_start_id), eid);
                chk(data_start_write === ewr, "R9 write flag", int'(data_start_write), int'(ewr));
            end

            // drive inputs for the edge that ends cycle k
            accept = 0;
            if (!busy && rq.size() > 0 && idle_cnt >= rq[0].gap) begin
                req_valid = 1'b1; req_write = rq[0].wr; req_addr = rq[0].addr; req_id = rq[0].id;
                accept = 1;
            end else if (busy && (k % 3 == 0)) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 32'hdead_beef; req_id = 4'hf;
            end else begin
                req_valid = 1'b0; req_addr = 32'h0123_4567;
            end

            // advance the model
            if (ecmd == 1) begin open_row[b] = -1; last_pre[b] = k; end
            else if (ecmd == 2) begin open_row[b] = r; last_act[b] = k; end
            else if (ecmd == 3 || ecmd == 4) begin
                pulse_t p;
                p.cyc = k + lat; p.id = int'(cur.id); p.wr = cur.wr;
                pq.push_back(p);
                last_col = k; busy = 0; idle_cnt = 0;
            end else if (!busy && !accept) begin
                idle_cnt++;
            end
            if (accept) begin cur = rq.pop_front(); busy = 1; end
            for (int i = pq.size() - 1; i >= 0; i--) if (pq[i].cyc <= k) pq.delete(i);

            if (rq.size() == 0 && !busy && pq.size() == 0) begin
                tail++;
                if (tail > 4) done = 1;
            end
        end

        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
        end
        chk(seen_pulses == total_reqs, "R9 pulse count", seen_pulses, total_reqs);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule